// File: doc/BRIEF.md
# Pulse Period and Width Capture Timer

This block measures an external signal with a 16-bit up-counter. The counter advances on a count tick that is picked from four prescaled enable inputs. When the resynchronised measurement input shows a qualifying edge on a tick, the running count is copied into a result register and the counter restarts from zero. The result therefore holds the distance between two qualifying edges, in ticks.

Software picks the edges to use with a 2-bit measurement field. The choices are falling-to-falling period, rising-to-rising period, or width, where every edge qualifies. A 2-bit source field picks the tick rate. While the start input is high the counter runs and the block raises edge and overflow interrupt pulses. The first edge of a run only arms the measurement, so it raises no interrupt and leaves the result marked as not valid. A sticky overflow flag can be read next to the mode fields. Only a mode write clears it, and only under the timing rule below.

Top module: `pcap_timer`

## Requirements
- R1: With measurement field 00 (falling to falling) or 01 (rising to rising) and source 00, `result_o` equals the number of ticks between two successive qualifying edges minus one, because the counter restarts at zero on each capture.
- R2: Measurement field 10 qualifies both edges, so the latest result is the preceding high or low time in ticks minus one, and every edge of a run except the first raises `edge_irq_o`.
- R3: Source field values 00, 01, 10 and 11 count on `tick_src_i[0]`, `[1]`, `[2]` and `[3]` respectively.
- R4: The counter advances only on selected ticks while `start_i` is 1. On the 65536th tick after reset without an edge it wraps to zero and raises a one-cycle `ovf_irq_o`, and `ovf_flag_o` rises in that same cycle.
- R5: The first qualifying edge after `start_i` rises raises no `edge_irq_o`. Each later qualifying edge raises a one-cycle pulse.
- R6: `result_valid_o` is 0 until the second qualifying edge of a run, is 1 from then on, and returns to 0 one cycle after `start_i` is 0.
- R7: `ovf_flag_o` clears on a mode write only while `start_i` is 1, and only once a tick has occurred since the flag was set. A mode write while stopped leaves the flag at 1.
- R8: Measurement field 11 qualifies no edge. The result stays unchanged and no edge interrupt is raised.
- R9: After reset, `result_o`, `result_valid_o`, `ovf_flag_o`, both interrupt outputs and `mode_o` are all zero.
- R10: A mode write stores `mode_wdata_i`, with bits [1:0] as the measurement field and bits [3:2] as the source field. `mode_o` returns it on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src_i | input | 4 | Count enables: base, /8, /32, slow clock /32 |
| meas_i | input | 1 | Asynchronous signal to be measured |
| start_i | input | 1 | 1 runs the counter, 0 stops it |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 4 | Mode write data {source, measurement} |
| mode_o | output | 4 | Mode register read value |
| ovf_flag_o | output | 1 | Sticky overflow flag, read only |
| result_o | output | 16 | Captured measurement |
| result_valid_o | output | 1 | Result holds a full measurement |
| edge_irq_o | output | 1 | Edge interrupt pulse |
| ovf_irq_o | output | 1 | Overflow interrupt pulse |

## Verification
A change on `meas_i` reaches the result two clock cycles for synchronisation later, plus the wait for the next selected tick, plus one register stage. Every edge pays the same delay. The bench therefore checks differences between edges that are whole multiples of the tick period, and samples the result only after the final edge has had a full tick period and more to land. Mode and flag updates appear one cycle after the write. The overflow pulse and the flag appear one cycle after the 65536th tick, and the bench counts cycles from the start edge to check that exact cycle.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  localparam int N_SRC = 4;
  localparam int SRC_W = $clog2(N_SRC);

  typedef enum logic [1:0] {
    MM_FALL_FALL = 2'b00,
    MM_RISE_RISE = 2'b01,
    MM_WIDTH     = 2'b10,
    MM_RSVD      = 2'b11
  } meas_mode_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_BASE  = 2'd0,
    SRC_DIV8  = 2'd1,
    SRC_DIV32 = 2'd2,
    SRC_SLOW  = 2'd3
  } cnt_src_e;

  typedef struct packed {
    cnt_src_e   src;
    meas_mode_e mode;
  } mode_reg_t;

  localparam int MODE_W = $bits(mode_reg_t);

endpackage

// File: rtl/pcap_edge_det.sv
module pcap_edge_det
  import pcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       meas_i,
  input  meas_mode_e mode_i,
  output logic       edge_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl;
  logic                   rise;
  logic                   fall;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= meas_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1];

  // previous level is sampled on every tick, running or not
  always_ff @(posedge clk) begin
    if (rst)         prev_q <= 1'b0;
    else if (tick_i) prev_q <= lvl;
  end

  assign rise = tick_i &  lvl & ~prev_q;
  assign fall = tick_i & ~lvl &  prev_q;

  always_comb begin
    case (mode_i)
      MM_FALL_FALL: edge_o = fall;
      MM_RISE_RISE: edge_o = rise;
      MM_WIDTH:     edge_o = rise | fall;
      default:      edge_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcap_counter.sv
module pcap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] result_o,
  output logic             valid_o,
  output logic             edge_irq_o,
  output logic             ovf_irq_o,
  output logic             ovf_evt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             step;

  assign step      = tick_i & run_i;
  // a capture on the same tick wins over the wrap
  assign ovf_evt_o = step & ~edge_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      result_o   <= '0;
      seen_q     <= 1'b0;
      valid_o    <= 1'b0;
      edge_irq_o <= 1'b0;
      ovf_irq_o  <= 1'b0;
    end else begin
      edge_irq_o <= 1'b0;
      ovf_irq_o  <= ovf_evt_o;
      if (!run_i) begin
        seen_q  <= 1'b0;
        valid_o <= 1'b0;
      end else if (tick_i) begin
        if (edge_i) begin
          result_o <= cnt_q;
          cnt_q    <= '0;
          seen_q   <= 1'b1;
          if (seen_q) begin
            valid_o    <= 1'b1;
            edge_irq_o <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + CNT_ONE;
        end
      end
    end
  end

  // R4
  counter_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt_q));

  // R5
  edge_irq_valid_chk: assert property (@(posedge clk) disable iff (rst)
    edge_irq_o |-> valid_o);

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> edge_irq_o);

  // R6
  valid_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !valid_o);

endmodule

// File: rtl/pcap_ovf_flag.sv
module pcap_ovf_flag (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic run_i,
  input  logic set_i,
  input  logic wr_i,
  output logic flag_o
);

  logic armed_q;
  logic clr;

  assign clr = flag_o & wr_i & run_i & (armed_q | tick_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_o  <= 1'b1;
      armed_q <= 1'b0;
    end else if (clr) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (flag_o && tick_i) begin
      armed_q <= 1'b1;
    end
  end

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_o) |-> $past(wr_i && run_i));

  // R7
  flag_stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !run_i) |=> flag_o);

endmodule

// File: rtl/pcap_timer.sv
module pcap_timer
  import pcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  tick_src_i,
  input  logic              meas_i,
  input  logic              start_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              ovf_flag_o,
  output logic [CNT_W-1:0]  result_o,
  output logic              result_valid_o,
  output logic              edge_irq_o,
  output logic              ovf_irq_o
);

  mode_reg_t mode_q;
  logic      tick;
  logic      edge_hit;
  logic      ovf_evt;

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= '0;
    else if (mode_wr_i) mode_q <= mode_reg_t'(mode_wdata_i);
  end

  assign mode_o = mode_q;
  assign tick   = tick_src_i[mode_q.src];

  pcap_edge_det #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .meas_i (meas_i),
    .mode_i (mode_q.mode),
    .edge_o (edge_hit)
  );

  pcap_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .run_i      (start_i),
    .edge_i     (edge_hit),
    .result_o   (result_o),
    .valid_o    (result_valid_o),
    .edge_irq_o (edge_irq_o),
    .ovf_irq_o  (ovf_irq_o),
    .ovf_evt_o  (ovf_evt)
  );

  pcap_ovf_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .run_i  (start_i),
    .set_i  (ovf_evt),
    .wr_i   (mode_wr_i),
    .flag_o (ovf_flag_o)
  );

  // R4
  ovf_flag_same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_irq_o |-> ovf_flag_o);

  // R4
  irq_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(edge_irq_o && ovf_irq_o));

  // R10
  mode_load_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr_i |=> (mode_o == $past(mode_wdata_i)));

endmodule

// File: tb/pcap_timer_tb.sv
module pcap_timer_tb;

  localparam int NV = 7;
  localparam int V_MODE [NV] = '{0, 1, 2, 0, 1, 2, 0};
  localparam int V_SRC  [NV] = '{0, 0, 0, 1, 2, 1, 3};
  localparam int V_HI   [NV] = '{10, 7, 20, 40, 64, 48, 128};
  localparam int V_LO   [NV] = '{15, 9, 30, 24, 64, 16, 192};
  localparam int V_EXP  [NV] = '{24, 15, 19, 7, 3, 5, 4};
  localparam int V_IRQ  [NV] = '{2, 2, 5, 2, 2, 5, 2};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  tick_src = 4'b0001;
  logic        meas = 1'b0;
  logic        start = 1'b0;
  logic        mode_wr = 1'b0;
  logic [3:0]  mode_wdata = 4'd0;
  logic [3:0]  mode_rd;
  logic        ovf_flag;
  logic [15:0] result;
  logic        valid;
  logic        edge_irq;
  logic        ovf_irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcap_timer u_dut (
    .clk            (clk),
    .rst            (rst),
    .tick_src_i     (tick_src),
    .meas_i         (meas),
    .start_i        (start),
    .mode_wr_i      (mode_wr),
    .mode_wdata_i   (mode_wdata),
    .mode_o         (mode_rd),
    .ovf_flag_o     (ovf_flag),
    .result_o       (result),
    .result_valid_o (valid),
    .edge_irq_o     (edge_irq),
    .ovf_irq_o      (ovf_irq)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_src[0] <= 1'b1;
    tick_src[1] <= ((cyc % 8) == 0);
    tick_src[2] <= ((cyc % 32) == 0);
    tick_src[3] <= ((cyc % 64) == 0);
  end

  always @(posedge clk) if (edge_irq) irq_cnt <= irq_cnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(input int src, input int mode);
    mode_wdata = 4'((src << 2) | mode);
    mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic pulses(input int hi, input int lo, input int reps);
    for (int r = 0; r < reps; r++) begin
      meas = 1'b1;
      wait_n(hi);
      meas = 1'b0;
      wait_n(lo);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    start = 1'b0;
    meas = 1'b0;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
  endtask

  initial begin
    int base;
    string tag;
    do_reset();

    // R9 reset state
    check(result == 16'd0, "R9", result, 0);
    check(valid == 1'b0 && ovf_flag == 1'b0, "R9", {valid, ovf_flag}, 0);
    check(edge_irq == 1'b0 && ovf_irq == 1'b0, "R9", {edge_irq, ovf_irq}, 0);
    check(mode_rd == 4'd0, "R9", mode_rd, 0);

    // R10 mode readback
    write_mode(2, 1);
    check(mode_rd == 4'b1001, "R10", mode_rd, 9);

    // vector table: R1 period, R2 width, R3 source select
    for (int i = 0; i < NV; i++) begin
      start = 1'b0;
      meas = 1'b0;
      wait_n(5);
      write_mode(V_SRC[i], V_MODE[i]);
      wait_n(70);
      base = irq_cnt;
      start = 1'b1;
      pulses(V_HI[i], V_LO[i], 3);
      if (V_MODE[i] == 2)      tag = "R2";
      else if (V_SRC[i] != 0)  tag = "R3";
      else                     tag = "R1";
      check(result == 16'(V_EXP[i]), tag, result, V_EXP[i]);
      check(irq_cnt - base == V_IRQ[i], "R5", irq_cnt - base, V_IRQ[i]);
      check(valid == 1'b1, "R6", valid, 1);
      if (i == 0) begin
        start = 1'b0;
        wait_n(1);
        check(valid == 1'b0, "R6", valid, 0);
      end
    end

    // R8 reserved measurement code captures nothing
    start = 1'b0;
    wait_n(5);
    write_mode(0, 3);
    wait_n(5);
    base = irq_cnt;
    start = 1'b1;
    pulses(10, 10, 3);
    check(result == 16'd4, "R8", result, 4);
    check(irq_cnt == base, "R8", irq_cnt - base, 0);
    check(valid == 1'b0, "R8", valid, 0);

    // R5 / R6 first edge arms only
    do_reset();
    write_mode(0, 1);
    wait_n(5);
    base = irq_cnt;
    start = 1'b1;
    meas = 1'b1;
    wait_n(12);
    check(valid == 1'b0, "R6", valid, 0);
    check(irq_cnt == base, "R5", irq_cnt - base, 0);
    meas = 1'b0;
    wait_n(8);
    meas = 1'b1;
    wait_n(6);
    check(valid == 1'b1, "R6", valid, 1);
    check(irq_cnt - base == 1, "R5", irq_cnt - base, 1);
    check(result == 16'd19, "R1", result, 19);

    // R4 overflow timing and flag
    do_reset();
    write_mode(0, 0);
    start = 1'b1;
    begin
      int n;
      n = 0;
      while (!ovf_irq && n < 70000) begin
        @(negedge clk);
        n++;
      end
      check(n == 65536, "R4", n, 65536);
      check(ovf_flag == 1'b1, "R4", ovf_flag, 1);
      @(negedge clk);
      check(ovf_irq == 1'b0, "R4", ovf_irq, 0);
    end

    // R7 clear rules
    start = 1'b0;
    wait_n(2);
    write_mode(0, 0);
    wait_n(1);
    check(ovf_flag == 1'b1, "R7", ovf_flag, 1);
    start = 1'b1;
    wait_n(2);
    write_mode(0, 0);
    check(ovf_flag == 1'b0, "R7", ovf_flag, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule